// File: doc/BRIEF.md
# Temperature Threshold Alarm Comparator

This block watches a stream of signed fixed-point temperature samples and raises an alarm when a sample crosses a programmable trip level. Each sample is a 16-bit two's-complement number with six fractional bits, so one LSB is 1/64 of a degree. Only on a cycle where the sample strobe is high does the block compare the sample with the stored trip level. The result of that comparison is kept on a live status output until the next valid sample arrives.

Software picks the comparison sense with a 2-bit code. In one sense the alarm fires at or below the trip level. In the other it fires at or above it. The two remaining codes switch the comparator off. A hit sets a sticky flag that holds until software clears it. The interrupt line is that flag gated by an enable bit, so software can silence the line after servicing it and leave the flag in place.

The trip level sits in its own register. A write is accepted only when the value is below the upper limit of the usable range (+125 degrees, raw 8000). Any other write is dropped and the register keeps its old value. After reset the trip level is one LSB below that limit.

Top module: `thermal_trip_cmp`

## Requirements
- R1: After a synchronous reset, `live_hit`, `flag` and `irq` are 0, and the stored trip level is raw 7999 (one LSB below +125 degrees).
- R2: With `sense_mode` = 0 (at-or-below), a valid sample whose signed value is less than or equal to the trip level drives `live_hit` to 1 on the next clock edge. Otherwise it drives `live_hit` to 0.
- R3: With `sense_mode` = 1 (at-or-above), a valid sample whose signed value is greater than or equal to the trip level drives `live_hit` to 1 on the next edge. Otherwise it drives `live_hit` to 0.
- R4: With `sense_mode` = 2 or 3, a valid sample drives `live_hit` to 0 and never sets `flag`.
- R5: A cycle with `sample_vld` low leaves `live_hit` and `flag` unchanged, whatever `sample`, `sense_mode` or the trip level do.
- R6: A valid sample that hits sets `flag` on the next edge. `flag` then stays at 1 through later non-hitting samples until it is cleared.
- R7: `flag_clr` clears `flag` on the next edge. When a hitting valid sample arrives in the same cycle as the clear, the set wins and `flag` stays 1.
- R8: `irq` is 1 exactly when `flag` and `irq_en` are both 1. It follows `irq_en` in the same cycle.
- R9: A trip-level write (`thr_wr` high) takes effect at the next edge only if the signed value of `thr_wdata` is below 8000. Any write at or above 8000 is ignored, and the previous trip level is kept.
- R10: All comparisons are signed two's-complement, so negative samples and negative trip levels order correctly (for example -1 is below 0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sample_vld | input | 1 | Marks `sample` as a new measurement this cycle |
| sample | input | 16 | Signed temperature sample, 1/64 degree per LSB |
| thr_wr | input | 1 | Write strobe for the trip level |
| thr_wdata | input | 16 | Signed trip level to write, 1/64 degree per LSB |
| sense_mode | input | 2 | 0: at-or-below, 1: at-or-above, 2/3: off |
| irq_en | input | 1 | Interrupt enable |
| flag_clr | input | 1 | Clears the sticky flag |
| live_hit | output | 1 | Result of the most recent valid comparison |
| flag | output | 1 | Sticky alarm flag |
| irq | output | 1 | Interrupt line |

## Verification
The assertions assume that every input is a clean 0 or 1 on each clock edge, and that `sense_mode` is stable on any cycle where `sample_vld` is high, because the comparison only uses it on that cycle. The bench changes every input half a period away from the sampling edge. It holds `sense_mode` and the sample together for the whole valid cycle, and it never pulses the strobe with unknown data. The range check on the stored trip level assumes reset comes first. The bench therefore holds reset for several cycles before it makes any write.

// File: rtl/tcmp_pkg.sv
package tcmp_pkg;

    localparam int TEMP_W        = 16;
    localparam int FRAC_BITS     = 6;
    localparam int HIGH_DEG      = 125;

    typedef enum logic [1:0] {
        SENSE_LE   = 2'd0,
        SENSE_GE   = 2'd1,
        SENSE_OFFA = 2'd2,
        SENSE_OFFB = 2'd3
    } sense_e;

    function automatic logic sense_hit(input sense_e mode,
                                       input logic  le_res,
                                       input logic  ge_res);
        logic r;
        case (mode)
            SENSE_LE: r = le_res;
            SENSE_GE: r = ge_res;
            default:  r = 1'b0;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/tcmp_thresh_reg.sv
module tcmp_thresh_reg #(
    parameter int W        = tcmp_pkg::TEMP_W,
    parameter int FRAC     = tcmp_pkg::FRAC_BITS,
    parameter int HIGH_DEG = tcmp_pkg::HIGH_DEG
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                wr,
    input  logic signed [W-1:0] wdata,
    output logic signed [W-1:0] thr_q
);
    localparam logic signed [W-1:0] LIMIT     = W'(HIGH_DEG * (2 ** FRAC));
    localparam logic signed [W-1:0] RESET_THR = LIMIT - W'(1);

    logic accept;
    assign accept = wr && (wdata < LIMIT);

    always_ff @(posedge clk) begin
        if (rst)
            thr_q <= RESET_THR;
        else if (accept)
            thr_q <= wdata;
    end
endmodule

// File: rtl/tcmp_compare.sv
module tcmp_compare #(
    parameter int W = tcmp_pkg::TEMP_W
) (
    input  logic signed [W-1:0] sample,
    input  logic signed [W-1:0] thr,
    input  logic [1:0]          mode,
    output logic                hit
);
    import tcmp_pkg::*;

    logic le_res;
    logic ge_res;

    always_comb begin
        le_res = (sample <= thr);
        ge_res = (sample >= thr);
        hit    = sense_hit(sense_e'(mode), le_res, ge_res);
    end
endmodule

// File: rtl/tcmp_alarm_flag.sv
module tcmp_alarm_flag (
    input  logic clk,
    input  logic rst,
    input  logic vld,
    input  logic hit,
    input  logic clr,
    input  logic en,
    output logic live_q,
    output logic flag_q,
    output logic irq
);
    logic set_now;
    assign set_now = vld && hit;

    always_ff @(posedge clk) begin
        if (rst) begin
            live_q <= 1'b0;
            flag_q <= 1'b0;
        end else begin
            if (vld)
                live_q <= hit;
            if (set_now)
                flag_q <= 1'b1;
            else if (clr)
                flag_q <= 1'b0;
        end
    end

    assign irq = flag_q && en;
endmodule

// File: rtl/thermal_trip_cmp.sv
module thermal_trip_cmp #(
    parameter int W        = tcmp_pkg::TEMP_W,
    parameter int FRAC     = tcmp_pkg::FRAC_BITS,
    parameter int HIGH_DEG = tcmp_pkg::HIGH_DEG
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         sample_vld,
    input  logic [W-1:0] sample,
    input  logic         thr_wr,
    input  logic [W-1:0] thr_wdata,
    input  logic [1:0]   sense_mode,
    input  logic         irq_en,
    input  logic         flag_clr,
    output logic         live_hit,
    output logic         flag,
    output logic         irq
);
    logic signed [W-1:0] thr_q;
    logic                hit;

    tcmp_thresh_reg #(.W(W), .FRAC(FRAC), .HIGH_DEG(HIGH_DEG)) u_thr (
        .clk   (clk),
        .rst   (rst),
        .wr    (thr_wr),
        .wdata ($signed(thr_wdata)),
        .thr_q (thr_q)
    );

    tcmp_compare #(.W(W)) u_cmp (
        .sample ($signed(sample)),
        .thr    (thr_q),
        .mode   (sense_mode),
        .hit    (hit)
    );

    tcmp_alarm_flag u_flag (
        .clk    (clk),
        .rst    (rst),
        .vld    (sample_vld),
        .hit    (hit),
        .clr    (flag_clr),
        .en     (irq_en),
        .live_q (live_hit),
        .flag_q (flag),
        .irq    (irq)
    );
endmodule

// File: rtl/thermal_trip_cmp_chk.sv
module thermal_trip_cmp_chk #(
    parameter int W        = tcmp_pkg::TEMP_W,
    parameter int FRAC     = tcmp_pkg::FRAC_BITS,
    parameter int HIGH_DEG = tcmp_pkg::HIGH_DEG
) (
    input logic                clk,
    input logic                rst,
    input logic                sample_vld,
    input logic [1:0]          sense_mode,
    input logic                irq_en,
    input logic                flag_clr,
    input logic                live_hit,
    input logic                flag,
    input logic                irq,
    input logic signed [W-1:0] thr_q
);
    localparam logic signed [W-1:0] LIMIT = W'(HIGH_DEG * (2 ** FRAC));

    p_off_modes_r4: assert property (@(posedge clk) disable iff (rst)
        (sample_vld && sense_mode[1]) |=> !live_hit);

    p_off_noset_r4: assert property (@(posedge clk) disable iff (rst)
        (sample_vld && sense_mode[1] && !flag) |=> !flag);

    p_live_hold_r5: assert property (@(posedge clk) disable iff (rst)
        !sample_vld |=> $stable(live_hit));

    p_sticky_r6: assert property (@(posedge clk) disable iff (rst)
        (flag && !flag_clr) |=> flag);

    p_rise_src_r6: assert property (@(posedge clk) disable iff (rst)
        (!flag && !sample_vld) |=> !flag);

    p_clear_r7: assert property (@(posedge clk) disable iff (rst)
        (flag_clr && !sample_vld) |=> !flag);

    p_irq_gate_r8: assert property (@(posedge clk) disable iff (rst)
        irq |-> (flag && irq_en));

    p_irq_on_r8: assert property (@(posedge clk) disable iff (rst)
        (flag && irq_en) |-> irq);

    p_thr_range_r9: assert property (@(posedge clk) disable iff (rst)
        thr_q < LIMIT);
endmodule

bind thermal_trip_cmp thermal_trip_cmp_chk #(.W(W), .FRAC(FRAC), .HIGH_DEG(HIGH_DEG)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .sample_vld (sample_vld),
    .sense_mode (sense_mode),
    .irq_en     (irq_en),
    .flag_clr   (flag_clr),
    .live_hit   (live_hit),
    .flag       (flag),
    .irq        (irq),
    .thr_q      (thr_q)
);

// File: tb/thermal_trip_cmp_tb.sv
`timescale 1ns/1ps
module thermal_trip_cmp_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        sample_vld = 1'b0;
    logic [15:0] sample = '0;
    logic        thr_wr = 1'b0;
    logic [15:0] thr_wdata = '0;
    logic [1:0]  sense_mode = 2'd0;
    logic        irq_en = 1'b0;
    logic        flag_clr = 1'b0;
    logic        live_hit, flag, irq;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    thermal_trip_cmp u_dut (
        .clk(clk), .rst(rst), .sample_vld(sample_vld), .sample(sample),
        .thr_wr(thr_wr), .thr_wdata(thr_wdata), .sense_mode(sense_mode),
        .irq_en(irq_en), .flag_clr(flag_clr),
        .live_hit(live_hit), .flag(flag), .irq(irq)
    );

    // Vector: {mode[1:0], trip[15:0], sample[15:0], expected hit}
    localparam int NV = 11;
    localparam logic [34:0] VEC [NV] = '{
        {2'd0, 16'h0780, 16'h0780, 1'b1},  // R2 equal
        {2'd0, 16'h0780, 16'h0781, 1'b0},  // R2 above
        {2'd0, 16'h0780, 16'hFD80, 1'b1},  // R2 / R10 negative sample
        {2'd1, 16'h0780, 16'h0780, 1'b1},  // R3 equal
        {2'd1, 16'h0780, 16'h077F, 1'b0},  // R3 below
        {2'd1, 16'h0780, 16'h1F3F, 1'b1},  // R3 high
        {2'd1, 16'hF600, 16'hF5FF, 1'b0},  // R3 / R10 both negative
        {2'd0, 16'hF600, 16'hF5FF, 1'b1},  // R2 / R10 both negative
        {2'd2, 16'h0780, 16'h0780, 1'b0},  // R4 code 2
        {2'd3, 16'h0780, 16'h0000, 1'b0},  // R4 code 3
        {2'd1, 16'h0000, 16'h8000, 1'b0}   // R10 most negative
    };

    task automatic check(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %b expected %b", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic write_thr(input logic [15:0] v);
        @(negedge clk);
        thr_wr = 1'b1;
        thr_wdata = v;
        tick();
        @(negedge clk);
        thr_wr = 1'b0;
    endtask

    task automatic clear_flag();
        @(negedge clk);
        flag_clr = 1'b1;
        tick();
        @(negedge clk);
        flag_clr = 1'b0;
    endtask

    task automatic apply(input logic [1:0] m, input logic [15:0] s);
        @(negedge clk);
        sense_mode = m;
        sample = s;
        sample_vld = 1'b1;
        tick();
        @(negedge clk);
        sample_vld = 1'b0;
    endtask

    function automatic string req_of(input logic [1:0] m);
        if (m == 2'd0) return "R2";
        if (m == 2'd1) return "R3";
        return "R4";
    endfunction

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual hung expected done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (4) @(posedge clk);
        #1;
        // R1 reset state
        check("R1 live_hit", live_hit, 1'b0);
        check("R1 flag", flag, 1'b0);
        check("R1 irq", irq, 1'b0);
        @(negedge clk);
        rst = 1'b0;

        // R1 reset trip level is 7999
        apply(2'd1, 16'd7999);
        check("R1 trip 7999 hit", live_hit, 1'b1);
        apply(2'd1, 16'd7998);
        check("R1 trip 7999 miss", live_hit, 1'b0);
        clear_flag();

        for (int i = 0; i < NV; i++) begin
            write_thr(VEC[i][32:17]);
            clear_flag();
            check("R7 clear", flag, 1'b0);
            apply(VEC[i][34:33], VEC[i][16:1]);
            check(req_of(VEC[i][34:33]), live_hit, VEC[i][0]);
            check("R6 flag set", flag, VEC[i][0]);
        end

        // R10 directed: -1 below 0
        write_thr(16'h0000);
        apply(2'd0, 16'hFFFF);
        check("R10 -1 <= 0", live_hit, 1'b1);

        // R6 sticky through a miss
        apply(2'd1, 16'hFFFF);
        check("R6 live miss", live_hit, 1'b0);
        check("R6 sticky", flag, 1'b1);

        // R8 irq gating
        @(negedge clk);
        irq_en = 1'b0;
        #1;
        check("R8 irq off", irq, 1'b0);
        irq_en = 1'b1;
        #1;
        check("R8 irq on", irq, 1'b1);

        // R5: no valid, inputs change, nothing moves
        @(negedge clk);
        sense_mode = 2'd0;
        sample = 16'hFFFF;
        tick();
        check("R5 live hold", live_hit, 1'b0);
        write_thr(16'h7000 - 16'h6000);
        check("R5 live hold thr", live_hit, 1'b0);
        check("R5 flag hold", flag, 1'b1);

        // R7 clear alone
        clear_flag();
        check("R7 cleared", flag, 1'b0);
        check("R8 irq follows", irq, 1'b0);

        // R7 set wins over clear
        write_thr(16'h0780);
        @(negedge clk);
        sense_mode = 2'd1;
        sample = 16'h0800;
        sample_vld = 1'b1;
        flag_clr = 1'b1;
        tick();
        check("R7 set wins", flag, 1'b1);
        @(negedge clk);
        sample_vld = 1'b0;
        flag_clr = 1'b0;
        clear_flag();

        // R9 reject write at limit, keep 1920
        write_thr(16'd8000);
        apply(2'd1, 16'd5000);
        check("R9 8000 ignored", live_hit, 1'b1);
        write_thr(16'h7FFF);
        apply(2'd1, 16'd5000);
        check("R9 7FFF ignored", live_hit, 1'b1);
        write_thr(16'd7999);
        apply(2'd1, 16'd5000);
        check("R9 7999 accepted", live_hit, 1'b0);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule